// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns bytes into asynchronous serial characters on a single output line. Bytes are pushed into a 16-entry, 8-bit-wide first-in first-out buffer. Whenever the line is free and transmission is allowed, the block pops the oldest byte and shifts it out as a character. Each character has a low start bit, the data bits, an optional parity bit and one or two high stop bits. Every bit lasts exactly one period of an external bit-rate pulse. This block does not generate that pulse.

The character format can be changed at run time while the block is between characters. The data length can be 5, 6, 7 or 8 bits. Parity can be off, odd or even. There can be one or two stop bits. A break request holds the line low for as long as it stays asserted, and no characters are sent during that time.

A character that has already started is always finished before a break or a disable takes effect. When bytes are queued, a new character follows the last stop bit with no idle gap.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `overflow` is 0. Whenever `busy` is 0, `txd` is 1.
- R2: A character is a 0 start bit, then the data bits least-significant first, then the stop bit(s) at 1. Every bit holds for one `bit_tick` period, and the line changes only in a cycle where `bit_tick` is high.
- R3: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Byte bits above the selected length are neither sent nor counted in parity.
- R4: `cfg_par` selects parity: 1 is odd, 2 is even, and 0 or 3 means no parity bit. When parity is on, the parity bit follows the last data bit. It makes the number of ones across the data bits and the parity bit odd (mode 1) or even (mode 2).
- R5: When `cfg_stop2` is 0 there is one stop bit, and when it is 1 there are two. A queued byte starts on the tick that ends the last stop bit, with no idle period in between.
- R6: A character starts only while `uart_on` and `tx_on` are both 1. Clearing either one during a character lets that character finish, and then no further character starts.
- R7: While `brk_req` is 1 and both enables are set, the line is driven low and held low from the first tick at which no character is in progress, and queued bytes stay in the buffer. A character in progress finishes first. The line returns high at the first tick after `brk_req` falls.
- R8: The buffer holds 16 bytes. They are sent in write order. `fifo_full` is set when 16 bytes are held, and `fifo_empty` is set when none are held.
- R9: A write while `fifo_full` is 1 is dropped and sets `overflow`, which stays set until reset.
- R10: `busy` is 1 from the start bit to the end of the last stop bit, and for the whole of a break.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse marking each bit period |
| uart_on | input | 1 | Global enable |
| tx_on | input | 1 | Transmit enable |
| cfg_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par | input | 2 | Parity mode (1 odd, 2 even, else none) |
| cfg_stop2 | input | 1 | Selects two stop bits |
| brk_req | input | 1 | Break request |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Character or break in progress |
| fifo_full | output | 1 | Buffer holds 16 bytes |
| fifo_empty | output | 1 | Buffer holds no bytes |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
A wrong bit counter or wrong sequencer state shows up on `txd` within one character. It appears as a data bit moved to another position, a missing or extra parity bit, or a stop bit sampled low. A back-to-back pair of characters catches a stop-bit count that is off by one, because the second start bit then arrives one bit period early or late. Wrong buffer pointers or a wrong occupancy count show up as out-of-order bytes, as full or empty flags at the wrong fill level, or as a character that is sent when it should not be. These appear within one buffer fill of 16 writes.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       uart_on,
  input  logic       tx_on,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       cfg_stop2,
  input  logic       brk_req,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       busy,
  output logic       fifo_full,
  output logic       fifo_empty,
  output logic       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t           state;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          stop_hi, par_q, txd_q, ovf_q;

  wire       en        = uart_on && tx_on;
  wire [2:0] last_bit  = 3'(cfg_len) + 3'd4;
  wire [7:0] mask      = 8'hFF >> (2'd3 - cfg_len);
  wire [7:0] head      = mem[rp] & mask;
  wire       has_par   = (cfg_par == 2'd1) || (cfg_par == 2'd2);
  wire       frame_end = (state == S_STOP) && (!cfg_stop2 || stop_hi);
  wire       at_rest   = (state == S_IDLE) || frame_end;
  wire       launch    = bit_tick && at_rest && en && !brk_req && !fifo_empty;
  wire       wr_ok     = wr_en && !fifo_full;

  assign fifo_full  = (cnt == CW'(DEPTH));
  assign fifo_empty = (cnt == '0);
  assign overflow   = ovf_q;
  assign txd        = txd_q;
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) if (wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf_q <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (launch) rp <= rp + AW'(1);
      cnt <= cnt + CW'(wr_ok) - CW'(launch);
      if (wr_en && fifo_full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; txd_q <= 1'b1; sh <= '0; bitn <= '0;
      stop_hi <= 1'b0; par_q <= 1'b0;
    end else if (bit_tick) begin
      if (at_rest) begin
        if (launch) begin
          state <= S_START; txd_q <= 1'b0; sh <= head;
          par_q <= (^head) ^ (cfg_par == 2'd1);
        end else if (brk_req && en) begin
          state <= S_BRK; txd_q <= 1'b0;
        end else begin
          state <= S_IDLE; txd_q <= 1'b1;
        end
      end else begin
        case (state)
          S_START: begin state <= S_DATA; txd_q <= sh[0]; bitn <= '0; end
          S_DATA:
            if (bitn == last_bit) begin
              if (has_par) begin state <= S_PAR; txd_q <= par_q; end
              else begin state <= S_STOP; txd_q <= 1'b1; stop_hi <= 1'b0; end
            end else begin
              sh <= sh >> 1; txd_q <= sh[1]; bitn <= bitn + 3'd1;
            end
          S_PAR:  begin state <= S_STOP; txd_q <= 1'b1; stop_hi <= 1'b0; end
          S_STOP: stop_hi <= 1'b1;
          S_BRK:  if (!brk_req) begin state <= S_IDLE; txd_q <= 1'b1; end
          default: begin state <= S_IDLE; txd_q <= 1'b1; end
        endcase
      end
    end
  end

  a_r1_rest_high: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n) (state == S_START) |-> !txd);
  a_r2_tick_paced: assert property (@(posedge clk) disable iff (!rst_n) !bit_tick |=> $stable(txd));
  a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n) (state == S_STOP) |-> txd);
  a_r6_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_IDLE) && !en) |=> (state != S_START));
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n) (state == S_BRK) |-> !txd);
  a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n) !(fifo_full && fifo_empty));
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic clk = 0, rst_n = 0, bit_tick = 0, uart_on = 1, tx_on = 1;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
  logic cfg_stop2 = 0, brk_req = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic txd, busy, fifo_full, fifo_empty, overflow;
  int nchk = 0, nfail = 0;

  uart_frame_tx uut (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .uart_on(uart_on),
    .tx_on(tx_on), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .brk_req(brk_req), .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .busy(busy),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow));

  always #5 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    bit_tick = 1;
    @(negedge clk);
    bit_tick = 0;
  end

  // {len, par, stop2, data, expected parity bit}
  localparam logic [13:0] VEC [7] = '{
    {2'd3, 2'd0, 1'b0, 8'h55, 1'b0},
    {2'd3, 2'd2, 1'b0, 8'hA7, 1'b1},
    {2'd3, 2'd1, 1'b1, 8'hA7, 1'b0},
    {2'd0, 2'd2, 1'b0, 8'hFF, 1'b1},
    {2'd1, 2'd1, 1'b1, 8'hC3, 1'b1},
    {2'd2, 2'd2, 1'b0, 8'h80, 1'b0},
    {2'd0, 2'd3, 1'b1, 8'h0A, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    int w = 0;
    while (busy && w < 3000) begin @(negedge clk); w++; end
    @(negedge clk);
  endtask

  task automatic rx(input int nd, input bit hp, input bit two, input int act,
                    output logic [7:0] d, output logic p, output logic sok);
    int w = 0;
    d = 0; p = 0; sok = 1;
    while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) begin
      chk(0, "R2 start bit seen", 32'(txd), 0);
      sok = 0;
      return;
    end
    if (act == 1) tx_on = 0;
    else if (act == 2) brk_req = 1;
    for (int i = 0; i < nd; i++) begin repeat (4) @(negedge clk); d[i] = txd; end
    if (hp) begin repeat (4) @(negedge clk); p = txd; end
    repeat (4) @(negedge clk); sok = txd;
    if (two) begin repeat (4) @(negedge clk); sok = sok & txd; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d, m;
    logic p, s;
    repeat (5) @(negedge clk);
    chk(txd && !busy && fifo_empty && !fifo_full && !overflow, "R1 reset state",
        {txd, busy, fifo_empty, fifo_full, overflow}, 5'b10100);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      wait_idle();
      cfg_len = VEC[i][13:12]; cfg_par = VEC[i][11:10]; cfg_stop2 = VEC[i][9];
      m = 8'hFF >> (3 - int'(cfg_len));
      put(VEC[i][8:1]);
      rx(int'(cfg_len) + 5, cfg_par == 2'd1 || cfg_par == 2'd2, cfg_stop2, 0, d, p, s);
      chk(d == (VEC[i][8:1] & m), "R2 R3 data bits", d, VEC[i][8:1] & m);
      if (cfg_par == 2'd1 || cfg_par == 2'd2) chk(p == VEC[i][0], "R4 parity bit", p, VEC[i][0]);
      chk(s == 1'b1, "R2 R5 stop bits high", s, 1);
    end

    // R5: two stop bits then immediate next start
    wait_idle();
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop2 = 1;
    put(8'h3C); put(8'hC3);
    rx(8, 0, 1, 0, d, p, s);
    chk(d == 8'h3C && s, "R5 first of pair", {d, 7'd0, s}, {8'h3C, 8'h01});
    repeat (4) @(negedge clk);
    chk(txd == 1'b0, "R5 next start right after second stop", txd, 0);
    rx(8, 0, 1, 0, d, p, s);
    chk(d == 8'hC3 && s, "R5 second of pair", {d, 7'd0, s}, {8'hC3, 8'h01});
    wait_idle();
    cfg_stop2 = 0;

    // R6: enables
    tx_on = 0;
    put(8'h5A);
    repeat (60) @(negedge clk);
    chk(!busy && txd, "R6 tx_on low holds", {busy, txd}, 2'b01);
    uart_on = 0; tx_on = 1;
    repeat (60) @(negedge clk);
    chk(!busy && txd, "R6 uart_on low holds", {busy, txd}, 2'b01);
    uart_on = 1;
    rx(8, 0, 0, 0, d, p, s);
    chk(d == 8'h5A && s, "R6 sends once enabled", d, 8'h5A);
    wait_idle();
    put(8'h96); put(8'h69);
    rx(8, 0, 0, 1, d, p, s);
    chk(d == 8'h96 && s, "R6 frame completes after disable", d, 8'h96);
    repeat (60) @(negedge clk);
    chk(!busy && txd && !fifo_empty, "R6 no new frame while off", {busy, txd, fifo_empty}, 3'b010);
    tx_on = 1;
    rx(8, 0, 0, 0, d, p, s);
    chk(d == 8'h69 && s, "R6 held byte sent later", d, 8'h69);

    // R7: break
    wait_idle();
    brk_req = 1;
    repeat (10) @(negedge clk);
    chk(!txd && busy, "R7 R10 break drives low", {txd, busy}, 2'b01);
    put(8'h11);
    repeat (40) @(negedge clk);
    chk(!txd && !fifo_empty, "R7 break holds byte", {txd, fifo_empty}, 2'b00);
    brk_req = 0;
    begin
      int w = 0;
      while (txd !== 1'b1 && w < 8) begin @(negedge clk); w++; end
      chk(txd == 1'b1, "R7 line released", txd, 1);
    end
    rx(8, 0, 0, 0, d, p, s);
    chk(d == 8'h11 && s, "R7 byte after break", d, 8'h11);
    wait_idle();
    put(8'hF0);
    rx(8, 0, 0, 2, d, p, s);
    chk(d == 8'hF0 && s, "R7 frame finishes before break", d, 8'hF0);
    repeat (4) @(negedge clk);
    chk(!txd && busy, "R7 break follows frame", {txd, busy}, 2'b01);
    brk_req = 0;
    wait_idle();

    // R8 / R9: buffer depth, order, overflow
    tx_on = 0;
    for (int i = 0; i < 16; i++) put(8'(i * 13 + 2));
    chk(fifo_full && !fifo_empty && !overflow, "R8 full after 16",
        {fifo_full, fifo_empty, overflow}, 3'b100);
    put(8'hEE);
    chk(overflow && fifo_full, "R9 overflow set", {overflow, fifo_full}, 2'b11);
    tx_on = 1;
    for (int i = 0; i < 16; i++) begin
      rx(8, 0, 0, 0, d, p, s);
      chk(d == 8'(i * 13 + 2), "R8 write order", d, 8'(i * 13 + 2));
    end
    wait_idle();
    repeat (40) @(negedge clk);
    chk(fifo_empty && !busy && txd && overflow, "R9 dropped byte not sent",
        {fifo_empty, busy, txd, overflow}, 4'b1011);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule